// File: doc/BRIEF.md
# Fully Associative Address Translation Cache

This block holds a small set of page-to-frame mappings and translates a 32-bit virtual address into a physical address. The upper twenty address bits form the virtual page number, which is compared against every stored entry at once. The lower twelve bits are the byte offset within a 4 KB page. On a hit, the stored frame number takes the place of the page number and the offset is carried across unchanged. The answer is registered and appears one cycle after the request.

Each entry stores a page number, a frame number, a process tag and four flags: valid, writable, referenced and dirty. When the process-tag option is enabled, a hit also needs the entry tag to equal the current process identifier. This lets mappings from several processes stay resident side by side. A flush clears every valid flag and leaves the other fields in place. When nothing matches, the block reports a miss, and an outside agent supplies the mapping through the refill port. A write to an entry that is not writable reports a protection fault instead.

A refill goes to the lowest-numbered empty slot. When every slot is in use, the refill overwrites the slot named by a rotating pointer, and the pointer then steps forward by one.

Top module: `va_xlat_cache`

## Requirements
- R1: On a hit, `rsp_pa` equals the stored frame number concatenated with request address bits 11..0. The page number is request bits 31..12.
- R2: A request sampled with `lk_req` high at one clock edge gives `rsp_vld` high after that edge, together with its result. Without a request, `rsp_vld`, `rsp_hit`, `rsp_miss` and `rsp_prot` are all low. All four are low after reset.
- R3: A hit requires a valid entry whose page number equals the request page number. With the process-tag option enabled (the default), the entry's tag must also equal `cur_pid`. The same page under another identifier misses.
- R4: When no entry qualifies under R3, the response is a miss. While `rsp_vld` is high, exactly one of hit, miss and protection fault is set, and a miss never comes with a protection fault.
- R5: A write (`lk_wr`=1) that matches an entry stored with writable=0 gives `rsp_prot` and no hit. Such an access changes neither the referenced flag nor the dirty flag of that entry. A read of the same entry is a normal hit.
- R6: On a hit, `rsp_ref` and `rsp_dirty` report the entry flags as they stood before the access. Every hit sets referenced, a write hit also sets dirty, and a refill stores both flags as 0.
- R7: A flush invalidates every entry. A lookup issued after the flush cycle misses until the mapping is refilled.
- R8: A refill writes the lowest-numbered invalid slot and leaves the rotating pointer unchanged.
- R9: When all slots are valid, a refill overwrites the slot at the rotating pointer. The pointer starts at slot 0 after reset and advances by one with wrap after each such eviction.
- R10: A lookup judges the contents as they stood before the cycle's refill, flush and flag update. A refill that comes in the same cycle as a flush leaves its entry valid. A refill that targets the entry hit in the same cycle replaces that entry's flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_req | input | 1 | Lookup request |
| lk_va | input | 32 | Virtual address to translate |
| lk_wr | input | 1 | Access is a write |
| cur_pid | input | PID_W | Current process identifier |
| fill_en | input | 1 | Write a new entry |
| fill_vpn | input | 20 | Page number of the new entry |
| fill_pfn | input | FRAME_W | Frame number of the new entry |
| fill_wr | input | 1 | New entry is writable |
| fill_pid | input | PID_W | Process tag of the new entry |
| flush | input | 1 | Invalidate all entries |
| rsp_vld | output | 1 | Response present |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_miss | output | 1 | No qualifying entry |
| rsp_prot | output | 1 | Write to a read-only entry |
| rsp_pa | output | FRAME_W+12 | Physical address, zero unless hit |
| rsp_ref | output | 1 | Referenced flag before this access |
| rsp_dirty | output | 1 | Dirty flag before this access |

## Verification
In a single cycle, a lookup can coincide with a refill, a flush, or a hit-flag update that a refill then overwrites. Directed steps set these up. One looks up a page while it is being filled, one looks up while flushing, and one fills during a flush. Each is followed by a second lookup, which shows that the first answer came from the old contents and the second from the new. Random traffic mixes all three at a fine grain. Every response is compared against a bench model that applies the R10 ordering each cycle.

// File: rtl/va_xlat_cache.sv
module va_xlat_cache #(
  parameter int DEPTH   = 64,
  parameter int FRAME_W = 20,
  parameter int PID_W   = 8,
  parameter bit USE_PID = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lk_req,
  input  logic [31:0]        lk_va,
  input  logic               lk_wr,
  input  logic [PID_W-1:0]   cur_pid,
  input  logic               fill_en,
  input  logic [19:0]        fill_vpn,
  input  logic [FRAME_W-1:0] fill_pfn,
  input  logic               fill_wr,
  input  logic [PID_W-1:0]   fill_pid,
  input  logic               flush,
  output logic               rsp_vld,
  output logic               rsp_hit,
  output logic               rsp_miss,
  output logic               rsp_prot,
  output logic [FRAME_W+11:0] rsp_pa,
  output logic               rsp_ref,
  output logic               rsp_dirty
);
  localparam int OFS_W = 12;
  localparam int VPN_W = 32 - OFS_W;
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [VPN_W-1:0]   e_vpn [DEPTH];
  logic [FRAME_W-1:0] e_pfn [DEPTH];
  logic [PID_W-1:0]   e_pid [DEPTH];
  logic [DEPTH-1:0]   e_v, e_w, e_r, e_d;

  logic [DEPTH-1:0] match;
  logic [IDX_W-1:0] hit_idx, free_idx, victim, rr;
  logic             any_hit, full, prot, upd;
  logic [VPN_W-1:0] q_vpn;

  assign q_vpn = lk_va[31:OFS_W];

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    if (USE_PID) begin : g_tag
      assign match[g] = e_v[g] && (e_vpn[g] == q_vpn) && (e_pid[g] == cur_pid);
    end else begin : g_notag
      assign match[g] = e_v[g] && (e_vpn[g] == q_vpn);
    end
  end

  always_comb begin
    hit_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (match[i]) hit_idx = IDX_W'(i);
  end

  always_comb begin
    free_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (!e_v[i]) free_idx = IDX_W'(i);
  end

  assign any_hit = |match;
  assign full    = &e_v;
  assign victim  = full ? rr : free_idx;
  assign prot    = any_hit && lk_wr && !e_w[hit_idx];
  assign upd     = lk_req && any_hit && !prot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_v <= '0;
      e_w <= '0;
      e_r <= '0;
      e_d <= '0;
      rr  <= '0;
    end else begin
      if (upd) begin
        e_r[hit_idx] <= 1'b1;
        if (lk_wr) e_d[hit_idx] <= 1'b1;
      end
      if (flush) e_v <= '0;
      if (fill_en) begin
        e_v[victim] <= 1'b1;
        e_w[victim] <= fill_wr;
        e_r[victim] <= 1'b0;
        e_d[victim] <= 1'b0;
        if (full) rr <= (rr == IDX_W'(DEPTH - 1)) ? '0 : rr + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      e_vpn[victim] <= fill_vpn;
      e_pfn[victim] <= fill_pfn;
      e_pid[victim] <= fill_pid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_vld   <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_prot  <= 1'b0;
      rsp_pa    <= '0;
      rsp_ref   <= 1'b0;
      rsp_dirty <= 1'b0;
    end else begin
      rsp_vld   <= lk_req;
      rsp_hit   <= upd;
      rsp_miss  <= lk_req && !any_hit;
      rsp_prot  <= lk_req && prot;
      rsp_pa    <= upd ? {e_pfn[hit_idx], lk_va[OFS_W-1:0]} : '0;
      rsp_ref   <= upd && e_r[hit_idx];
      rsp_dirty <= upd && e_d[hit_idx];
    end
  end
endmodule

// File: rtl/va_xlat_cache_chk.sv
module va_xlat_cache_chk #(
  parameter int FRAME_W = 20
) (
  input logic               clk,
  input logic               rst_n,
  input logic               lk_req,
  input logic [31:0]        lk_va,
  input logic               lk_wr,
  input logic               fill_en,
  input logic               flush,
  input logic               rsp_vld,
  input logic               rsp_hit,
  input logic               rsp_miss,
  input logic               rsp_prot,
  input logic [FRAME_W+11:0] rsp_pa
);
  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n) lk_req |=> rsp_vld); // R2
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n) !lk_req |=> !rsp_vld); // R2
  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !rsp_vld |-> !(rsp_hit || rsp_miss || rsp_prot)); // R2
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n) rsp_vld |-> $countones({rsp_hit, rsp_miss, rsp_prot}) == 1); // R4
  AST_MISS_EXCL_PROT: assert property (@(posedge clk) disable iff (!rst_n) !(rsp_miss && rsp_prot)); // R4
  AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n) lk_req |=> (!rsp_hit || rsp_pa[11:0] == $past(lk_va[11:0]))); // R1
  AST_PROT_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n) (lk_req && !lk_wr) |=> !rsp_prot); // R5
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n) (lk_req && $past(flush) && !$past(fill_en)) |=> rsp_miss); // R7
endmodule

bind va_xlat_cache va_xlat_cache_chk #(.FRAME_W(FRAME_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_va(lk_va), .lk_wr(lk_wr),
  .fill_en(fill_en), .flush(flush), .rsp_vld(rsp_vld), .rsp_hit(rsp_hit),
  .rsp_miss(rsp_miss), .rsp_prot(rsp_prot), .rsp_pa(rsp_pa)
);

// File: tb/sim_va_xlat_cache.sv
module sim_va_xlat_cache;
  localparam int CLK_T = 10;
  localparam int D = 64;

  logic clk = 1'b0, rst_n = 1'b0;
  logic lk_req = 0, lk_wr = 0, fill_en = 0, fill_wr = 0, flush = 0;
  logic [31:0] lk_va = '0;
  logic [7:0] cur_pid = '0, fill_pid = '0;
  logic [19:0] fill_vpn = '0, fill_pfn = '0;
  logic rsp_vld, rsp_hit, rsp_miss, rsp_prot, rsp_ref, rsp_dirty;
  logic [31:0] rsp_pa;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [19:0] m_vpn [D];
  logic [19:0] m_pfn [D];
  logic [7:0]  m_pid [D];
  bit m_v [D], m_w [D], m_r [D], m_d [D];
  int m_rr = 0;

  always #(CLK_T/2) clk = ~clk;

  va_xlat_cache u0 (
    .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_va(lk_va), .lk_wr(lk_wr),
    .cur_pid(cur_pid), .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn),
    .fill_wr(fill_wr), .fill_pid(fill_pid), .flush(flush), .rsp_vld(rsp_vld),
    .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_prot(rsp_prot), .rsp_pa(rsp_pa),
    .rsp_ref(rsp_ref), .rsp_dirty(rsp_dirty)
  );

  task automatic cmp(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int find(input logic [19:0] vpn, input logic [7:0] pid);
    for (int i = 0; i < D; i++)
      if (m_v[i] && m_vpn[i] == vpn && m_pid[i] == pid) return i;
    return -1;
  endfunction

  function automatic int pick_slot();
    for (int i = 0; i < D; i++) if (!m_v[i]) return i;
    return -1;
  endfunction

  task automatic step(input bit req, input logic [31:0] va, input bit wr, input logic [7:0] pid,
                      input bit fe, input logic [19:0] fv, input logic [19:0] fp, input bit fw,
                      input logic [7:0] fpid, input bit fl, input string tag);
    int h, s;
    bit eh, em, ep, er, ed;
    logic [31:0] epa;
    lk_req = req; lk_va = va; lk_wr = wr; cur_pid = pid;
    fill_en = fe; fill_vpn = fv; fill_pfn = fp; fill_wr = fw; fill_pid = fpid; flush = fl;
    h = find(va[31:12], pid);
    em = req && (h < 0);
    ep = req && (h >= 0) && wr && !m_w[h];
    eh = req && (h >= 0) && !ep;
    epa = eh ? {m_pfn[h], va[11:0]} : 32'h0;
    er = eh && m_r[h];
    ed = eh && m_d[h];
    s = pick_slot();
    if (eh) begin m_r[h] = 1; if (wr) m_d[h] = 1; end
    if (fl) for (int i = 0; i < D; i++) m_v[i] = 0;
    if (fe) begin
      if (s < 0) begin s = m_rr; m_rr = (m_rr + 1) % D; end
      m_v[s] = 1; m_w[s] = fw; m_r[s] = 0; m_d[s] = 0;
      m_vpn[s] = fv; m_pfn[s] = fp; m_pid[s] = fpid;
    end
    @(posedge clk);
    @(negedge clk);
    lk_req = 0; fill_en = 0; flush = 0;
    cmp({tag, " vld"}, 64'(rsp_vld), 64'(req));
    cmp({tag, " hit/miss/prot"}, 64'({rsp_hit, rsp_miss, rsp_prot}), 64'({eh, em, ep}));
    if (eh) begin
      cmp({tag, " pa"}, 64'(rsp_pa), 64'(epa));
      cmp({tag, " ref/dirty"}, 64'({rsp_ref, rsp_dirty}), 64'({er, ed}));
    end
  endtask

  task automatic look(input logic [31:0] va, input bit wr, input logic [7:0] pid, input string tag);
    step(1, va, wr, pid, 0, 20'h0, 20'h0, 0, 8'h0, 0, tag);
  endtask

  task automatic fill(input logic [19:0] fv, input logic [19:0] fp, input bit fw,
                      input logic [7:0] fpid, input string tag);
    step(0, 32'h0, 0, 8'h0, 1, fv, fp, fw, fpid, 0, tag);
  endtask

  initial begin
    for (int i = 0; i < D; i++) begin
      m_v[i] = 0; m_w[i] = 0; m_r[i] = 0; m_d[i] = 0;
      m_vpn[i] = '0; m_pfn[i] = '0; m_pid[i] = '0;
    end
    repeat (3) @(negedge clk);
    cmp("R2 reset vld", 64'(rsp_vld), 64'h0);
    cmp("R2 reset flags", 64'({rsp_hit, rsp_miss, rsp_prot}), 64'h0);
    rst_n = 1;
    @(negedge clk);
    look(32'h12345678, 0, 8'd1, "R4 empty miss");
    fill(20'h12345, 20'hABCDE, 1, 8'd1, "R8 fill");
    look(32'h12345678, 0, 8'd1, "R1 hit translate");
    look(32'h12345FFF, 1, 8'd1, "R6 write hit ref");
    look(32'h12345000, 0, 8'd1, "R6 dirty seen");
    look(32'h12345678, 0, 8'd2, "R3 other pid miss");
    fill(20'h00042, 20'h00777, 0, 8'd1, "R8 fill ro");
    look(32'h00042010, 1, 8'd1, "R5 prot fault");
    look(32'h00042010, 0, 8'd1, "R5 read after prot");
    step(1, 32'h00099ABC, 0, 8'd1, 1, 20'h00099, 20'h11111, 1, 8'd1, 0, "R10 look during fill");
    look(32'h00099ABC, 0, 8'd1, "R10 hit after fill");
    step(1, 32'h00099ABC, 0, 8'd1, 0, 20'h0, 20'h0, 0, 8'h0, 1, "R10 look during flush");
    look(32'h00099ABC, 0, 8'd1, "R7 miss after flush");
    look(32'h12345678, 0, 8'd1, "R7 miss after flush b");
    step(0, 32'h0, 0, 8'h0, 1, 20'h12345, 20'h22222, 1, 8'd1, 1, "R10 fill with flush");
    look(32'h12345678, 0, 8'd1, "R6 R10 fresh flags");
    step(1, 32'h12345678, 1, 8'd1, 1, 20'h00500, 20'h33333, 1, 8'd1, 0, "R10 hit with fill");
    // fill until full, then evict
    step(0, 32'h0, 0, 8'h0, 0, 20'h0, 20'h0, 0, 8'h0, 1, "R7 flush");
    for (int i = 0; i < D; i++) fill(20'h00100 + 20'(i), 20'h40000 + 20'(i), 1, 8'd3, "R8 fill all");
    fill(20'h00200, 20'h50000, 1, 8'd3, "R9 evict");
    look(32'h00100000, 0, 8'd3, "R9 slot0 gone");
    look(32'h00101000, 0, 8'd3, "R9 slot1 kept");
    fill(20'h00201, 20'h50001, 1, 8'd3, "R9 evict next");
    look(32'h00101000, 0, 8'd3, "R9 slot1 gone");
    look(32'h00200000, 0, 8'd3, "R9 new hit");
    step(0, 32'h0, 0, 8'h0, 0, 20'h0, 20'h0, 0, 8'h0, 1, "R7 flush");
    for (int i = 0; i < D; i++) fill(20'h00300 + 20'(i), 20'h60000 + 20'(i), 1, 8'd3, "R8 refill all");
    fill(20'h00400, 20'h70000, 1, 8'd3, "R9 pointer kept");
    look(32'h00302000, 0, 8'd3, "R8 R9 slot2 gone");
    look(32'h00300000, 0, 8'd3, "R8 slot0 kept");
    begin
      int unsigned seed_dummy;
      seed_dummy = $urandom(32'h5EED);
    end
    for (int n = 0; n < 3000; n++) begin
      logic [19:0] v, fv;
      logic [7:0] p, fp;
      bit rq, fe, fl;
      v  = 20'($urandom_range(0, 95));
      p  = 8'($urandom_range(1, 2));
      fv = 20'($urandom_range(0, 95));
      fp = 8'($urandom_range(1, 2));
      rq = ($urandom_range(0, 9) < 7);
      fe = ($urandom_range(0, 9) < 3) && (find(fv, fp) < 0);
      fl = ($urandom_range(0, 63) == 0);
      step(rq, {v, 12'($urandom())}, 1'($urandom()), p, fe, fv, 20'($urandom()),
           1'($urandom_range(0, 3) != 0), fp, fl, "R3 R4 R5 R6 R10 random");
    end
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin @(posedge clk); cyc++; end
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual %0d expected done", cyc);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule